// File: doc/BRIEF.md
# Multi-Algorithm Converter Sequencer

This block is the digital half of an analog-to-digital converter that is built from an external DAC and a single comparator. On each clock the sequencer presents a code to the DAC and reads back one comparator bit. That bit says whether the DAC level is above the analog input. From these answers the sequencer finds the largest code whose DAC level is not above the input. It then returns that code as the result, together with a one-cycle done strobe.

Three search algorithms are available, and one is picked by a mode input when a conversion starts:

- **Ramp** climbs from zero in unit steps.
- **Tracking** walks up or down from the previous result. It is quick when the input moves slowly.
- **Successive approximation** settles one bit per cycle, starting from the MSB.

The surrounding logic pulses start. It then waits for done and reads the result, which holds until the next conversion ends.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, result_o and dac_code_o are all zero. The stored previous result is also zero, so the first tracking conversion after reset begins at code 0.
- R2: A start_i pulse while the block is idle makes busy_o high from the next cycle. A start_i pulse while busy_o is high has no effect on the running conversion, its result or its length.
- R3: mode_i is sampled only on the accepted start: 2'b00 selects ramp, 2'b01 selects tracking, and 2'b10 or 2'b11 select successive approximation. Changes of mode_i during a conversion have no effect.
- R4: cmp_above_i is high when the DAC level for dac_code_o is above the input. For an input at integer level T, every mode returns result_o = T, the largest code not above the input.
- R5: Ramp mode presents code 0 first and increments by one each cycle. It ends on the first compare that reports above, with result = that code minus one. For T below all-ones this takes T+2 compares.
- R6: If ramp mode reaches all-ones without an above compare, it ends there with result all-ones after 2^WIDTH compares.
- R7: Tracking mode presents the previous result first. It steps down by one after an above compare and up by one otherwise. It ends when the direction differs from the previous step's direction. The result is the code minus one if the final compare was above, otherwise the code. This gives T-P+2 compares upward and P-T+1 downward from previous result P.
- R8: Tracking mode ends at all-ones after a not-above compare and at zero after an above compare, and returns that end code.
- R9: Successive approximation presents the MSB alone first. It keeps each trial bit only if the compare is not above, then trials the next lower bit. It ends after exactly WIDTH compares.
- R10: done_o is a single-cycle pulse in the cycle after the terminating compare. busy_o falls in that same cycle, and result_o changes only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, honoured only when idle |
| mode_i | input | 2 | Algorithm select, sampled at start |
| cmp_above_i | input | 1 | Comparator: DAC level above the input |
| dac_code_o | output | WIDTH | Code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| result_o | output | WIDTH | Last converted code |

## Verification
Each conversion costs a known number of compares, where one compare is one clock with busy_o high. That number is T+2 or 2^WIDTH for ramp and WIDTH for successive approximation. For tracking it is T-P+2, P-T+1 or the distance to the rail. done_o is due exactly one edge after the last compare. The bench counts edges from the start edge to the first sample with done_o high, and checks that count against the formula, plus one for the start edge. It reads the first DAC code one edge after start and checks the result and the done pulse width at the falling edges around done.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    CONV_RAMP  = 2'b00,
    CONV_TRACK = 2'b01,
    CONV_SAR   = 2'b10
  } conv_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // Both codes with bit 1 set pick successive approximation.
  function automatic conv_mode_e decode_mode(input logic [1:0] sel);
    if (sel[1])      return CONV_SAR;
    else if (sel[0]) return CONV_TRACK;
    else             return CONV_RAMP;
  endfunction

endpackage

// File: rtl/adc_seq_seed.sv
module adc_seq_seed
  import adc_seq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  conv_mode_e       mode,
  input  logic [WIDTH-1:0] prev_result,
  output logic [WIDTH-1:0] seed_code
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  always_comb begin
    unique case (mode)
      CONV_TRACK: seed_code = prev_result;
      CONV_SAR:   seed_code = TOP_BIT;
      default:    seed_code = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_count_step.sv
module adc_seq_count_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] code,
  input  logic             above,
  input  logic             track,
  input  logic             first,
  input  logic             last_up,
  output logic [WIDTH-1:0] next_code,
  output logic             step_up,
  output logic             finish,
  output logic [WIDTH-1:0] settle
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic at_top;
  logic at_bottom;
  logic flip;

  always_comb begin
    at_top    = &code;
    at_bottom = (code == '0);
    step_up   = !above;
    flip      = !first && (step_up != last_up);
    // Largest code not above the input, as seen from this compare.
    settle    = (above && !at_bottom) ? code - ONE : code;
    if (track) begin
      next_code = step_up ? code + ONE : code - ONE;
      finish    = flip || (step_up && at_top) || (!step_up && at_bottom);
    end else begin
      next_code = code + ONE;
      finish    = above || at_top;
    end
  end
endmodule

// File: rtl/adc_seq_sar_step.sv
module adc_seq_sar_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] code,
  input  logic [WIDTH-1:0] trial,
  input  logic             above,
  output logic [WIDTH-1:0] next_code,
  output logic [WIDTH-1:0] next_trial,
  output logic             finish,
  output logic [WIDTH-1:0] settle
);
  always_comb begin
    settle     = above ? (code & ~trial) : code;
    next_trial = trial >> 1;
    next_code  = settle | next_trial;
    finish     = trial[0];
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  // Reset synchroniser: assert asynchronously, release on the clock.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  seq_state_e       state_q, state_d;
  conv_mode_e       mode_q, mode_d;
  logic [WIDTH-1:0] code_q, code_d;
  logic [WIDTH-1:0] trial_q, trial_d;
  logic [WIDTH-1:0] result_q, result_d;
  logic             first_q, first_d;
  logic             up_q, up_d;
  logic             done_q, done_d;

  conv_mode_e       start_mode;
  logic [WIDTH-1:0] seed_code;
  logic [WIDTH-1:0] cnt_next, cnt_settle, sar_next, sar_trial, sar_settle;
  logic             cnt_up, cnt_fin, sar_fin;
  logic             accept, running, ctx_en, result_en;

  assign start_mode = decode_mode(mode_i);

  adc_seq_seed #(.WIDTH(WIDTH)) u_seed (
    .mode        (start_mode),
    .prev_result (result_q),
    .seed_code   (seed_code)
  );

  adc_seq_count_step #(.WIDTH(WIDTH)) u_count (
    .code      (code_q),
    .above     (cmp_above_i),
    .track     (mode_q == CONV_TRACK),
    .first     (first_q),
    .last_up   (up_q),
    .next_code (cnt_next),
    .step_up   (cnt_up),
    .finish    (cnt_fin),
    .settle    (cnt_settle)
  );

  adc_seq_sar_step #(.WIDTH(WIDTH)) u_sar (
    .code       (code_q),
    .trial      (trial_q),
    .above      (cmp_above_i),
    .next_code  (sar_next),
    .next_trial (sar_trial),
    .finish     (sar_fin),
    .settle     (sar_settle)
  );

  // Next-state logic.
  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    code_d   = code_q;
    trial_d  = trial_q;
    result_d = result_q;
    first_d  = first_q;
    up_d     = up_q;
    done_d   = 1'b0;
    accept   = (state_q == ST_IDLE) && start_i;
    running  = (state_q == ST_RUN);

    if (accept) begin
      state_d = ST_RUN;
      mode_d  = start_mode;
      code_d  = seed_code;
      trial_d = TOP_BIT;
      first_d = 1'b1;
    end else if (running) begin
      if (mode_q == CONV_SAR) begin
        code_d  = sar_fin ? sar_settle : sar_next;
        trial_d = sar_trial;
        if (sar_fin) begin
          state_d  = ST_IDLE;
          result_d = sar_settle;
          done_d   = 1'b1;
        end
      end else begin
        first_d = 1'b0;
        up_d    = cnt_up;
        code_d  = cnt_fin ? code_q : cnt_next;
        if (cnt_fin) begin
          state_d  = ST_IDLE;
          result_d = cnt_settle;
          done_d   = 1'b1;
        end
      end
    end
    ctx_en    = accept || running;
    result_en = done_d;
  end

  // Registers with explicit enables.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= CONV_RAMP;
      code_q   <= '0;
      trial_q  <= '0;
      first_q  <= 1'b0;
      up_q     <= 1'b0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q  <= done_d;
      state_q <= state_d;
      if (ctx_en) begin
        mode_q  <= mode_d;
        code_q  <= code_d;
        trial_q <= trial_d;
        first_q <= first_d;
        up_q    <= up_d;
      end
      if (result_en) result_q <= result_d;
    end
  end

  assign dac_code_o = code_q;
  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign result_o   = result_q;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [1:0]       mode_prev;
  logic             busy_prev;
  logic             sar_run;
  logic [WIDTH+1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_prev <= '0;
      busy_prev <= 1'b0;
      sar_run   <= 1'b0;
      busy_cnt  <= '0;
    end else begin
      mode_prev <= mode_i;
      busy_prev <= busy_o;
      if (busy_o && !busy_prev) sar_run <= mode_prev[1];
      busy_cnt <= busy_o ? busy_cnt + 1'b1 : '0;
    end
  end

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_ramp_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && $past(mode_i) == 2'b00) |-> dac_code_o == '0);

  assert_track_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && $past(mode_i) == 2'b01) |-> dac_code_o == $past(result_o));

  assert_sar_seed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && $past(mode_i[1])) |-> dac_code_o == TOP_BIT);

  assert_sar_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && sar_run) |-> busy_cnt == (WIDTH+2)'(WIDTH));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .dac_code_o (dac_code_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;
  localparam int NVEC = 12;

  // Each entry: {mode[1:0], input level[7:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'b00, 8'd0},   {2'b00, 8'd37},  {2'b00, 8'd255}, {2'b01, 8'd40},
    {2'b01, 8'd45},  {2'b01, 8'd45},  {2'b10, 8'd0},   {2'b10, 8'd255},
    {2'b10, 8'd170}, {2'b11, 8'd85},  {2'b01, 8'd0},   {2'b01, 8'd255}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   mode_i;
  logic         cmp_above_i;
  logic [W-1:0] dac_code_o;
  logic         busy_o;
  logic         done_o;
  logic [W-1:0] result_o;
  int           level;
  int           checks = 0;
  int           errors = 0;
  int           cycles = 0;

  always #2 clk = ~clk;

  // Behavioural comparator: DAC code above the input level.
  assign cmp_above_i = (int'(dac_code_o) > level);

  adc_seq_ctrl #(.WIDTH(W)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .cmp_above_i(cmp_above_i), .dac_code_o(dac_code_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o)
  );

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: act %0d cycles exp fewer", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  // Latency in edges from the start edge to the done sample (compares + 1).
  function automatic int exp_lat(input logic [1:0] m, input int t, input int p);
    int k;
    if (m[1])           k = W;
    else if (m == 2'b00) k = (t < MAXV) ? t + 2 : MAXV + 1;
    else if (t >= p)     k = (t < MAXV) ? t - p + 2 : MAXV - p + 1;
    else                 k = p - t + 1;
    return k + 1;
  endfunction

  function automatic int exp_seed(input logic [1:0] m, input int p);
    if (m[1])           return 1 << (W - 1);
    else if (m == 2'b01) return p;
    else                return 0;
  endfunction

  task automatic run_conv(input logic [1:0] m, input int t, input int stray_at,
                          output int res, output int lat, output int seed);
    level = t;
    @(negedge clk);
    mode_i  = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seed = int'(dac_code_o);
    lat  = 1;
    while (!done_o && lat < 2000) begin
      if (lat == stray_at) begin
        start_i = 1'b1;
        mode_i  = ~m;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    res = int'(result_o);
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    start_i = 1'b0;
    mode_i  = 2'b00;
    level   = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int prev, res, lat, seed;
    do_reset();
    // R1: idle state after reset
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 result", int'(result_o), 0);
    chk("R1 code", int'(dac_code_o), 0);

    prev = 0;
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] m;
      int t;
      m = VEC[i][9:8];
      t = int'(VEC[i][7:0]);
      run_conv(m, t, -1, res, lat, seed);
      // R4 result; R5/R7/R9 seed; R5 R6 R7 R8 R9 length; R3 mode decode
      chk($sformatf("R4 result vec %0d", i), res, t);
      chk($sformatf("R5/R7/R9 seed vec %0d", i), seed, exp_seed(m, prev));
      chk($sformatf("R6/R8/R10 latency vec %0d (R3 mode %0d)", i, m), lat, exp_lat(m, t, prev));
      @(negedge clk);
      // R10: one-cycle pulse, result held, idle
      chk($sformatf("R10 pulse vec %0d", i), int'(done_o), 0);
      chk($sformatf("R10 hold vec %0d", i), int'(result_o), t);
      chk($sformatf("R10 busy vec %0d", i), int'(busy_o), 0);
      prev = t;
    end

    // R2 and R3: a stray start with another mode mid-ramp changes nothing
    run_conv(2'b00, 150, 20, res, lat, seed);
    chk("R2 stray start result", res, 150);
    chk("R3 stray mode latency", lat, exp_lat(2'b00, 150, prev));
    prev = 150;

    // R1: reset mid-conversion clears the previous result
    level = 200;
    @(negedge clk);
    mode_i  = 2'b00;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    do_reset();
    chk("R1 mid reset busy", int'(busy_o), 0);
    chk("R1 mid reset result", int'(result_o), 0);
    run_conv(2'b01, 3, -1, res, lat, seed);
    chk("R1 track seed after reset", seed, 0);
    chk("R7 track result after reset", res, 3);
    chk("R7 track latency after reset", lat, exp_lat(2'b01, 3, 0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule